// File: doc/BRIEF.md
# Shared-Memory Mailbox with Ownership Handoff

A 256-bit message window shared by two agents: a requester that posts commands and a responder that answers them. The window is eight 32-bit words, and each agent reaches it through its own word-addressed port, with a write strobe and a read that returns data one cycle after the address is presented. The top bit of the last word is an ownership flag. While the flag is 0 the requester may fill the window. Its write to the last word acts as a doorbell: the flag goes to 1, the responder receives a notify pulse, and further requester writes are refused. The responder then writes its answer into the last word with the flag bit clear. Ownership returns to the requester, which receives its own notify pulse.

A function-reset input models the requester side being held in reset. While it is asserted, every word reads as all ones on both ports and all writes are discarded. When it is released the window is zero, the requester owns it, and the sticky error bit is clear. A requester write refused because the responder owns the window sets a sticky error bit.

Top module: `shm_mailbox`

## Requirements
- R1: Each of the eight 32-bit words (word index = address 0..7) can be written by either port, and a read on either port returns the addressed word on the cycle after the address is presented.
- R2: Bit 31 of word 7 is the owner flag and reads back on both ports: 1 means the responder owns the window, 0 means the requester owns it.
- R3: A requester write to word 7 while the flag is 0 stores bits 30:0 of the data and sets the flag to 1, whatever value bit 31 of the written data has.
- R4: A requester write to word 7 alone (a header-only message) leaves words 0..6 unchanged.
- R5: While the flag is 1, requester writes to any word change nothing, and the requester error output goes to 1. It stays at 1 until function reset or block reset.
- R6: The responder may write any word at any time. A responder write to word 7 takes bit 31 from its data. When both ports write the same word in one cycle, the responder data is kept.
- R7: The responder notify output is high for exactly one cycle when the flag goes from 0 to 1. The requester notify output is high for exactly one cycle when the flag goes from 1 to 0 through a responder write. The flag clearing under function reset gives no pulse.
- R8: While fn_rst_i is 1, both read ports return 0xFFFFFFFF on the next cycle and writes are discarded. After release, all words read 0, the flag is 0 and the error output is 0.
- R9: With rst_ni low, all words, the flag, the error output, both notify outputs and both read data outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous block reset, active low |
| fn_rst_i | input | 1 | Function reset: all-ones reads, writes discarded, clears on release |
| req_we_i | input | 1 | Requester write strobe |
| req_addr_i | input | 3 | Requester word index |
| req_wdata_i | input | 32 | Requester write data |
| req_rdata_o | output | 32 | Requester read data, one cycle after address |
| req_err_o | output | 1 | Sticky: a requester write was refused |
| req_notify_o | output | 1 | One-cycle pulse when ownership returns to the requester |
| rsp_we_i | input | 1 | Responder write strobe |
| rsp_addr_i | input | 3 | Responder word index |
| rsp_wdata_i | input | 32 | Responder write data |
| rsp_rdata_o | output | 32 | Responder read data, one cycle after address |
| rsp_notify_o | output | 1 | One-cycle pulse when the requester rings the doorbell |

## Verification
Two situations are hardest to reach from the ports. The first is a same-cycle write by both agents to one word while the requester still owns the window: only that case shows which agent's data is kept. The bench drives both strobes in the same cycle from one task. The second is a function reset asserted while the responder owns the window, which must clear the flag without a requester notify pulse. The bench rings the doorbell first, raises fn_rst_i, and samples req_notify_o on the following cycle.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned MBX_DWORDS = 8;
  localparam int unsigned MBX_DW     = 32;
  typedef enum logic {OWN_REQ = 1'b0, OWN_RSP = 1'b1} owner_e;
endpackage

// File: rtl/mbx_store.sv
module mbx_store #(
  parameter int unsigned DWORDS = 8,
  parameter int unsigned DW     = 32,
  localparam int unsigned AW    = $clog2(DWORDS)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         clr_i,
  input  logic                         rsp_we_i,
  input  logic [AW-1:0]                rsp_addr_i,
  input  logic [DW-1:0]                rsp_wdata_i,
  input  logic                         req_we_i,
  input  logic [AW-1:0]                req_addr_i,
  input  logic [DW-1:0]                req_wdata_i,
  output logic [DWORDS-1:0][DW-1:0]    words_o
);
  localparam int unsigned LAST = DWORDS - 1;

  for (genvar i = 0; i < DWORDS; i++) begin : g_word
    logic rsp_hit, req_hit;
    assign rsp_hit = rsp_we_i && (rsp_addr_i == AW'(i));
    assign req_hit = req_we_i && (req_addr_i == AW'(i));
    if (i == LAST) begin : g_last
      // top bit lives in the owner logic
      logic [DW-2:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      q <= '0;
        else if (clr_i)   q <= '0;
        else if (rsp_hit) q <= rsp_wdata_i[DW-2:0];
        else if (req_hit) q <= req_wdata_i[DW-2:0];
      end
      assign words_o[i] = {1'b0, q};
    end else begin : g_full
      logic [DW-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      q <= '0;
        else if (clr_i)   q <= '0;
        else if (rsp_hit) q <= rsp_wdata_i;
        else if (req_hit) q <= req_wdata_i;
      end
      assign words_o[i] = q;
      // R6: responder wins a same-word collision
      a_r6_rsp_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rsp_hit && !clr_i) |=> (q == $past(rsp_wdata_i)));
    end
  end
endmodule

// File: rtl/mbx_owner.sv
module mbx_owner
  import mbx_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic req_we_i,
  input  logic req_last_i,
  input  logic rsp_we_last_i,
  input  logic rsp_own_bit_i,
  output logic own_o,
  output logic req_acc_o,
  output logic rsp_notify_o,
  output logic req_notify_o,
  output logic err_o
);
  owner_e own_q, own_d;
  logic   err_q;

  assign req_acc_o = req_we_i && (own_q == OWN_REQ) && !clr_i;

  always_comb begin
    own_d = own_q;
    if (clr_i)                      own_d = OWN_REQ;
    else if (rsp_we_last_i)         own_d = owner_e'(rsp_own_bit_i);
    else if (req_acc_o && req_last_i) own_d = OWN_RSP;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      own_q        <= OWN_REQ;
      err_q        <= 1'b0;
      rsp_notify_o <= 1'b0;
      req_notify_o <= 1'b0;
    end else begin
      own_q        <= own_d;
      rsp_notify_o <= !clr_i && own_d == OWN_RSP && own_q == OWN_REQ;
      req_notify_o <= !clr_i && own_d == OWN_REQ && own_q == OWN_RSP;
      if (clr_i)                                     err_q <= 1'b0;
      else if (req_we_i && own_q == OWN_RSP)         err_q <= 1'b1;
    end
  end

  assign own_o = (own_q == OWN_RSP);
  assign err_o = err_q;

  a_r3_doorbell_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_acc_o && req_last_i && !rsp_we_last_i) |=> own_o);
  a_r5_drop_sets_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_we_i && own_o && !clr_i) |=> err_o);
  a_r5_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !clr_i) |=> err_o);
  a_r7_rsp_pulse_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_notify_o |-> (own_o && !$past(own_o)));
  a_r7_pulses_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rsp_notify_o, req_notify_o}));
  a_r8_clr_no_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!req_notify_o && !own_o));
endmodule

// File: rtl/mbx_rd_port.sv
module mbx_rd_port #(
  parameter int unsigned DWORDS = 8,
  parameter int unsigned DW     = 32,
  localparam int unsigned AW    = $clog2(DWORDS)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      clr_i,
  input  logic [AW-1:0]             addr_i,
  input  logic [DWORDS-1:0][DW-1:0] words_i,
  output logic [DW-1:0]             rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rdata_o <= '0;
    else if (clr_i) rdata_o <= '1;
    else            rdata_o <= words_i[addr_i];
  end

  a_r8_reset_reads_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (rdata_o == '1));
endmodule

// File: rtl/shm_mailbox.sv
module shm_mailbox
  import mbx_pkg::*;
#(
  parameter int unsigned DWORDS = MBX_DWORDS,
  parameter int unsigned DW     = MBX_DW,
  localparam int unsigned AW    = $clog2(DWORDS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fn_rst_i,
  input  logic          req_we_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic [DW-1:0] req_rdata_o,
  output logic          req_err_o,
  output logic          req_notify_o,
  input  logic          rsp_we_i,
  input  logic [AW-1:0] rsp_addr_i,
  input  logic [DW-1:0] rsp_wdata_i,
  output logic [DW-1:0] rsp_rdata_o,
  output logic          rsp_notify_o
);
  localparam int unsigned LAST    = DWORDS - 1;
  localparam int unsigned OWN_BIT = DW - 1;

  logic                      own, req_acc, rsp_we_ok;
  logic [DWORDS-1:0][DW-1:0] words, view;

  assign rsp_we_ok = rsp_we_i && !fn_rst_i;

  mbx_owner u_owner (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .clr_i         (fn_rst_i),
    .req_we_i      (req_we_i),
    .req_last_i    (req_addr_i == AW'(LAST)),
    .rsp_we_last_i (rsp_we_ok && (rsp_addr_i == AW'(LAST))),
    .rsp_own_bit_i (rsp_wdata_i[OWN_BIT]),
    .own_o         (own),
    .req_acc_o     (req_acc),
    .rsp_notify_o  (rsp_notify_o),
    .req_notify_o  (req_notify_o),
    .err_o         (req_err_o)
  );

  mbx_store #(.DWORDS(DWORDS), .DW(DW)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (fn_rst_i),
    .rsp_we_i    (rsp_we_ok),
    .rsp_addr_i  (rsp_addr_i),
    .rsp_wdata_i (rsp_wdata_i),
    .req_we_i    (req_acc),
    .req_addr_i  (req_addr_i),
    .req_wdata_i (req_wdata_i),
    .words_o     (words)
  );

  always_comb begin
    view                = words;
    view[LAST][OWN_BIT] = own;
  end

  mbx_rd_port #(.DWORDS(DWORDS), .DW(DW)) u_rd_req (
    .clk_i (clk_i), .rst_ni (rst_ni), .clr_i (fn_rst_i),
    .addr_i (req_addr_i), .words_i (view), .rdata_o (req_rdata_o)
  );

  mbx_rd_port #(.DWORDS(DWORDS), .DW(DW)) u_rd_rsp (
    .clk_i (clk_i), .rst_ni (rst_ni), .clr_i (fn_rst_i),
    .addr_i (rsp_addr_i), .words_i (view), .rdata_o (rsp_rdata_o)
  );

  // R5: a refused requester write leaves the whole window untouched
  a_r5_drop_keeps_words: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_we_i && own && !rsp_we_i && !fn_rst_i) |=> $stable(view));
  // R4: a doorbell write touches only the last word
  a_r4_header_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_acc && req_addr_i == AW'(LAST) && !rsp_we_i) |=>
      (view[LAST-1:0] == $past(view[LAST-1:0])));
endmodule

// File: tb/tb_shm_mailbox.sv
`timescale 1ns/1ps
module tb_shm_mailbox;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        fn_rst_i = 1'b0;
  logic        req_we_i = 1'b0, rsp_we_i = 1'b0;
  logic [2:0]  req_addr_i = '0, rsp_addr_i = '0;
  logic [31:0] req_wdata_i = '0, rsp_wdata_i = '0;
  logic [31:0] req_rdata_o, rsp_rdata_o;
  logic        req_err_o, req_notify_o, rsp_notify_o;

  always #4 clk_i = ~clk_i;

  shm_mailbox dut (.*);

  typedef struct {
    bit          port;
    logic [31:0] exp;
    int          cyc;
    string       tag;
  } sb_item_t;

  sb_item_t    sb[$];
  int          cyc = 0;
  int          n_cmp = 0, n_err = 0;
  logic [31:0] em [8];

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // monitor: compare read data one cycle after the address was issued
  always @(negedge clk_i) begin
    sb_item_t it;
    while (sb.size() > 0 && sb[0].cyc < cyc) begin
      it = sb.pop_front();
      chk(it.tag, it.port ? rsp_rdata_o : req_rdata_o, it.exp);
    end
  end

  task automatic rd(input bit port, input int a, input logic [31:0] e, input string tag);
    sb_item_t it;
    if (port) rsp_addr_i = 3'(a); else req_addr_i = 3'(a);
    it.port = port; it.exp = e; it.cyc = cyc; it.tag = tag;
    sb.push_back(it);
    @(negedge clk_i);
  endtask

  task automatic wr(input bit port, input int a, input logic [31:0] d);
    if (port) begin rsp_we_i = 1'b1; rsp_addr_i = 3'(a); rsp_wdata_i = d; end
    else      begin req_we_i = 1'b1; req_addr_i = 3'(a); req_wdata_i = d; end
    @(negedge clk_i);
    req_we_i = 1'b0; rsp_we_i = 1'b0;
  endtask

  task automatic wr_both(input int a, input logic [31:0] dq, input logic [31:0] dp);
    req_we_i = 1'b1; req_addr_i = 3'(a); req_wdata_i = dq;
    rsp_we_i = 1'b1; rsp_addr_i = 3'(a); rsp_wdata_i = dp;
    @(negedge clk_i);
    req_we_i = 1'b0; rsp_we_i = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_err++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) em[i] = '0;
    @(negedge clk_i);
    // R9: block reset state
    chk("R9 rdata_req", req_rdata_o, '0);
    chk("R9 rdata_rsp", rsp_rdata_o, '0);
    chk("R9 err", 32'(req_err_o), 0);
    chk("R9 notify", {30'd0, req_notify_o, rsp_notify_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    for (int i = 0; i < 8; i++) rd(0, i, '0, "R9 word zero");

    // R1: requester fills words 0..6, both ports read back
    for (int i = 0; i < 7; i++) begin
      em[i] = 32'h1357_9BDF ^ (32'(i) * 32'h0101_1011);
      wr(0, i, em[i]);
    end
    for (int i = 0; i < 7; i++) rd(0, i, em[i], "R1 req read");
    for (int i = 0; i < 7; i++) rd(1, i, em[i], "R1 rsp read");

    // R3/R7: doorbell with bit 31 clear still sets the flag
    wr(0, 7, 32'h0000_0123);
    chk("R7 rsp_notify rise", 32'(rsp_notify_o), 1);
    chk("R7 req_notify quiet", 32'(req_notify_o), 0);
    em[7] = 32'h8000_0123;
    rd(1, 7, em[7], "R3 flag set");
    chk("R7 rsp_notify one cycle", 32'(rsp_notify_o), 0);
    rd(0, 7, em[7], "R2 flag visible on req port");

    // R5: refused writes while responder owns
    chk("R5 err before", 32'(req_err_o), 0);
    wr(0, 2, 32'hDEAD_BEEF);
    chk("R5 err set", 32'(req_err_o), 1);
    rd(0, 2, em[2], "R5 word unchanged");
    wr(0, 7, 32'h0000_0000);
    rd(1, 7, em[7], "R5 last word unchanged");

    // R6: responder writes mid-window, keeps flag with bit 31 set
    em[3] = 32'hA5A5_0003;
    wr(1, 3, em[3]);
    rd(0, 3, em[3], "R6 rsp write word3");
    wr(1, 7, 32'h8000_0011);
    chk("R6 no req_notify while flag kept", 32'(req_notify_o), 0);
    em[7] = 32'h8000_0011;
    rd(0, 7, em[7], "R6 flag kept");

    // R6/R7: responder hands back ownership
    wr(1, 7, 32'h0000_0042);
    chk("R7 req_notify fall", 32'(req_notify_o), 1);
    chk("R7 rsp_notify quiet", 32'(rsp_notify_o), 0);
    em[7] = 32'h0000_0042;
    rd(0, 7, em[7], "R6 flag cleared");
    chk("R7 req_notify one cycle", 32'(req_notify_o), 0);
    chk("R5 err sticky", 32'(req_err_o), 1);

    // R6: same-cycle collision, responder data kept
    em[5] = 32'h5555_AAAA;
    wr_both(5, 32'h1111_2222, em[5]);
    rd(0, 5, em[5], "R6 collision");

    // R4: header-only doorbell
    wr(0, 7, 32'h0000_0007);
    em[7] = 32'h8000_0007;
    rd(1, 7, em[7], "R4 header word");
    for (int i = 0; i < 7; i++) rd(1, i, em[i], "R4 payload unchanged");

    // R8: function reset while responder owns
    fn_rst_i = 1'b1;
    @(negedge clk_i);
    chk("R8 no req_notify", 32'(req_notify_o), 0);
    chk("R8 req reads ones", req_rdata_o, 32'hFFFF_FFFF);
    chk("R8 rsp reads ones", rsp_rdata_o, 32'hFFFF_FFFF);
    rd(0, 4, 32'hFFFF_FFFF, "R8 ones word4");
    wr(1, 1, 32'h1234_5678);
    wr(0, 0, 32'h8765_4321);
    rd(1, 1, 32'hFFFF_FFFF, "R8 ones word1");
    fn_rst_i = 1'b0;
    @(negedge clk_i);
    chk("R8 err cleared", 32'(req_err_o), 0);
    for (int i = 0; i < 8; i++) rd(0, i, '0, "R8 zero after release");
    chk("R8 no pulse after release", {30'd0, req_notify_o, rsp_notify_o}, 0);

    @(negedge clk_i);
    @(negedge clk_i);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end
endmodule